// File: doc/BRIEF.md
# Two-Word Keyed Watchdog Timer

This block is a watchdog down-counter that software controls through a small write port. The counter can be started, refreshed or stopped. Each of these actions needs two consecutive writes of fixed 32-bit words to the control register: an arming word, then a confirming word. A stray store into the register therefore cannot start, refresh or stop the timer by accident. While the timer runs, it counts down by one on each cycle where the tick-enable input is high. When it reaches zero, it raises a one-cycle reset request, stops counting and records the cause in a flag. That flag survives the system reset that the request produces.

A configuration register holds the reset-type select bit, which is driven out on `fullBusRst`. That bit changes only when the same write also carries a qualifier bit. The parameter `CAN_STOP` chooses between two builds: one that accepts a stop sequence, and one in which the stop words are not recognised, so a running timer can never be halted. The parameter `CNT_W` sets the counter width. The reload value is always all ones, so the timeout is 2^CNT_W − 1 ticks.

Register map (`wrAddr` / `rdAddr`):
- 0: writes go to control, reads return the counter zero-extended.
- 1: configuration. Bit 0 is the reset-type select, bit 31 is the write qualifier. Reads return bit 0 only.
- 2: cause. Bit 5 is the expiry flag, and writing 1 to bit 5 clears it.
- 3: reads as 0.

Top module: `keyed_watchdog`

## Requirements
- R1: After `porRstN` the timer is stopped, the counter reads all ones, no word is armed, the cause flag and the configuration bit are 0, and `rstReq` is low.
- R2: A control write of 0x1E1E1E1E followed, as the next control write, by 0xE1E1E1E1 sets `timerOn` and reloads the counter to all ones.
- R3: While `timerOn` is high, the counter drops by exactly one on each clock edge where `tickEn` is 1, and holds where `tickEn` is 0. While stopped, it never changes on a tick.
- R4: Repeating the start sequence while running reloads the counter to all ones (keepalive).
- R5: Any control write other than the matching confirm word, made while a sequence is armed, cancels the armed state and leaves the counter and `timerOn` unchanged. A confirm word written afterwards on its own then has no effect.
- R6: With `CAN_STOP`=1, a control write of 0x1F1F1F1F followed by 0xF1F1F1F1 clears `timerOn`, and the counter then holds its value despite ticks.
- R7: With `CAN_STOP`=0, the words 0x1F1F1F1F and 0xF1F1F1F1 do not stop the timer, and counting goes on.
- R8: When a tick takes the running counter from 1 to 0, `rstReq` is high for exactly one cycle, `timerOn` clears, the counter stays at 0, and cause bit 5 reads 1, all from the same edge.
- R9: The cause flag is kept through `sysRstN`. It is cleared by `porRstN` or by writing 1 to bit 5 of address 2. A write with bit 5 at 0 leaves it unchanged.
- R10: A write to address 1 updates the select bit from bit 0 only when bit 31 of the data is 1. The select bit drives `fullBusRst` and reads back at bit 0.
- R11: `sysRstN` low stops the timer, reloads the counter to all ones and clears any armed sequence, but keeps the configuration bit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| porRstN | input | 1 | Power-on reset, active low, asynchronous; clears everything |
| sysRstN | input | 1 | System reset, active low, synchronous; spares cause flag and configuration |
| tickEn | input | 1 | Count enable, one decrement per high cycle |
| wrEn | input | 1 | Register write strobe |
| wrAddr | input | 2 | Write register address |
| wrData | input | 32 | Write data |
| rdAddr | input | 2 | Read register address |
| rdData | output | 32 | Read data, combinational |
| timerOn | output | 1 | Timer is running |
| rstReq | output | 1 | One-cycle reset request on expiry |
| fullBusRst | output | 1 | Reset-type select bit |

## Verification
The bound checker checks the following on every cycle:
- the counter steps by one per tick while running and is frozen while stopped;
- the reset request is a one-cycle pulse that coincides with the cause flag and with the timer turning off;
- the cause flag only rises with a request and only falls through its clear write;
- the select bit only moves on a qualified configuration write.

Some behaviours depend on the order of writes, so only the directed scenarios can show them:
- that the arm and confirm words must arrive back to back;
- that a foreign word cancels the arm;
- that keepalive reloads the counter;
- that the no-stop build ignores the stop words;
- that the cause flag persists across a system reset while a power-on reset clears it.

// File: rtl/keyed_watchdog_pkg.sv
package keyed_watchdog_pkg;
  localparam logic [31:0] START_ARM_WORD  = 32'h1E1E_1E1E;
  localparam logic [31:0] START_CONF_WORD = 32'hE1E1_E1E1;
  localparam logic [31:0] STOP_ARM_WORD   = 32'h1F1F_1F1F;
  localparam logic [31:0] STOP_CONF_WORD  = 32'hF1F1_F1F1;

  localparam logic [1:0] ADDR_CTRL  = 2'd0;
  localparam logic [1:0] ADDR_CFG   = 2'd1;
  localparam logic [1:0] ADDR_CAUSE = 2'd2;

  localparam int CAUSE_BIT   = 5;
  localparam int CFG_SEL_BIT = 0;
  localparam int CFG_QUAL_BIT = 31;

  typedef enum logic [1:0] {
    ARM_NONE  = 2'd0,
    ARM_START = 2'd1,
    ARM_STOP  = 2'd2
  } armState_t;

  typedef struct packed {
    logic reload;
    logic halt;
  } cntStrobe_t;
endpackage

// File: rtl/keyed_watchdog_count.sv
module keyed_watchdog_count
  import keyed_watchdog_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             porRstN,
  input  logic             sysRstN,
  input  logic             tickEn,
  input  cntStrobe_t       strobe,
  output logic [CNT_W-1:0] cntVal,
  output logic             running,
  output logic             hitZero,
  output logic             rstReq
);
  localparam logic [CNT_W-1:0] RELOAD_VAL = '1;
  localparam logic [CNT_W-1:0] LAST_VAL   = CNT_W'(1);

  assign hitZero = sysRstN && running && tickEn && !strobe.reload &&
                   !strobe.halt && (cntVal == LAST_VAL);

  always_ff @(posedge clk or negedge porRstN) begin
    if (!porRstN) begin
      cntVal  <= RELOAD_VAL;
      running <= 1'b0;
      rstReq  <= 1'b0;
    end else if (!sysRstN) begin
      cntVal  <= RELOAD_VAL;
      running <= 1'b0;
      rstReq  <= 1'b0;
    end else begin
      rstReq <= hitZero;
      if (strobe.reload) begin
        cntVal  <= RELOAD_VAL;
        running <= 1'b1;
      end else if (strobe.halt) begin
        running <= 1'b0;
      end else if (running && tickEn) begin
        cntVal <= cntVal - LAST_VAL;
        if (cntVal == LAST_VAL) running <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/keyed_watchdog_ctrl.sv
module keyed_watchdog_ctrl
  import keyed_watchdog_pkg::*;
#(
  parameter int CNT_W    = 32,
  parameter bit CAN_STOP = 1'b1
) (
  input  logic             clk,
  input  logic             porRstN,
  input  logic             sysRstN,
  input  logic             wrEn,
  input  logic [1:0]       wrAddr,
  input  logic [31:0]      wrData,
  input  logic [1:0]       rdAddr,
  input  logic [CNT_W-1:0] cntVal,
  input  logic             hitZero,
  output cntStrobe_t       strobe,
  output logic [31:0]      rdData,
  output logic             causeFlag,
  output logic             fullBusRst
);
  armState_t armState;
  logic ctlWr, cfgWr, causeWr;
  logic stopArmHit, stopConfHit;
  logic startDone, stopDone;

  assign ctlWr   = wrEn && (wrAddr == ADDR_CTRL);
  assign cfgWr   = wrEn && (wrAddr == ADDR_CFG);
  assign causeWr = wrEn && (wrAddr == ADDR_CAUSE);

  generate
    if (CAN_STOP) begin : g_stop
      assign stopArmHit  = (wrData == STOP_ARM_WORD);
      assign stopConfHit = (wrData == STOP_CONF_WORD);
    end else begin : g_noStop
      assign stopArmHit  = 1'b0;
      assign stopConfHit = 1'b0;
    end
  endgenerate

  assign startDone = sysRstN && ctlWr && (armState == ARM_START) &&
                     (wrData == START_CONF_WORD);
  assign stopDone  = sysRstN && ctlWr && (armState == ARM_STOP) && stopConfHit;

  always_comb begin
    strobe.reload = startDone;
    strobe.halt   = stopDone;
  end

  always_ff @(posedge clk or negedge porRstN) begin
    if (!porRstN) begin
      armState <= ARM_NONE;
    end else if (!sysRstN) begin
      armState <= ARM_NONE;
    end else if (ctlWr) begin
      if (startDone || stopDone)             armState <= ARM_NONE;
      else if (wrData == START_ARM_WORD)     armState <= ARM_START;
      else if (stopArmHit)                   armState <= ARM_STOP;
      else                                   armState <= ARM_NONE;
    end
  end

  always_ff @(posedge clk or negedge porRstN) begin
    if (!porRstN) begin
      fullBusRst <= 1'b0;
    end else if (cfgWr && wrData[CFG_QUAL_BIT]) begin
      fullBusRst <= wrData[CFG_SEL_BIT];
    end
  end

  always_ff @(posedge clk or negedge porRstN) begin
    if (!porRstN) begin
      causeFlag <= 1'b0;
    end else if (hitZero) begin
      causeFlag <= 1'b1;
    end else if (causeWr && wrData[CAUSE_BIT]) begin
      causeFlag <= 1'b0;
    end
  end

  always_comb begin
    rdData = '0;
    unique case (rdAddr)
      ADDR_CTRL:  rdData = 32'(cntVal);
      ADDR_CFG:   rdData[CFG_SEL_BIT] = fullBusRst;
      ADDR_CAUSE: rdData[CAUSE_BIT] = causeFlag;
      default:    rdData = '0;
    endcase
  end
endmodule

// File: rtl/keyed_watchdog.sv
module keyed_watchdog
  import keyed_watchdog_pkg::*;
#(
  parameter int CNT_W    = 32,
  parameter bit CAN_STOP = 1'b1
) (
  input  logic        clk,
  input  logic        porRstN,
  input  logic        sysRstN,
  input  logic        tickEn,
  input  logic        wrEn,
  input  logic [1:0]  wrAddr,
  input  logic [31:0] wrData,
  input  logic [1:0]  rdAddr,
  output logic [31:0] rdData,
  output logic        timerOn,
  output logic        rstReq,
  output logic        fullBusRst
);
  cntStrobe_t       strobe;
  logic [CNT_W-1:0] cntVal;
  logic             hitZero;
  logic             causeFlag;

  keyed_watchdog_ctrl #(.CNT_W(CNT_W), .CAN_STOP(CAN_STOP)) ctrlInst (
    .clk(clk), .porRstN(porRstN), .sysRstN(sysRstN),
    .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData), .rdAddr(rdAddr),
    .cntVal(cntVal), .hitZero(hitZero), .strobe(strobe),
    .rdData(rdData), .causeFlag(causeFlag), .fullBusRst(fullBusRst)
  );

  keyed_watchdog_count #(.CNT_W(CNT_W)) countInst (
    .clk(clk), .porRstN(porRstN), .sysRstN(sysRstN), .tickEn(tickEn),
    .strobe(strobe), .cntVal(cntVal), .running(timerOn),
    .hitZero(hitZero), .rstReq(rstReq)
  );
endmodule

// File: rtl/keyed_watchdog_chk.sv
module keyed_watchdog_chk #(
  parameter int CNT_W = 32
) (
  input logic             clk,
  input logic             porRstN,
  input logic             sysRstN,
  input logic             tickEn,
  input logic             ctlWr,
  input logic             cfgWr,
  input logic             causeClr,
  input logic             timerOn,
  input logic             rstReq,
  input logic             causeFlag,
  input logic             fullBusRst,
  input logic [CNT_W-1:0] cntVal
);
  // R3
  count_step_chk: assert property (@(posedge clk) disable iff (!porRstN || !sysRstN)
    (timerOn && tickEn && !ctlWr) |=> (cntVal == CNT_W'($past(cntVal) - CNT_W'(1))));

  // R3
  count_hold_chk: assert property (@(posedge clk) disable iff (!porRstN || !sysRstN)
    ((!timerOn || !tickEn) && !ctlWr) |=> $stable(cntVal));

  // R8
  req_pulse_chk: assert property (@(posedge clk) disable iff (!porRstN || !sysRstN)
    rstReq |=> !rstReq);

  // R8
  req_effect_chk: assert property (@(posedge clk) disable iff (!porRstN || !sysRstN)
    rstReq |-> (causeFlag && !timerOn && (cntVal == '0)));

  // R8
  cause_rise_chk: assert property (@(posedge clk) disable iff (!porRstN || !sysRstN)
    $rose(causeFlag) |-> rstReq);

  // R9
  cause_keep_chk: assert property (@(posedge clk) disable iff (!porRstN)
    (causeFlag && !causeClr) |=> causeFlag);

  // R10
  cfg_stable_chk: assert property (@(posedge clk) disable iff (!porRstN)
    !cfgWr |=> $stable(fullBusRst));
endmodule

bind keyed_watchdog keyed_watchdog_chk #(.CNT_W(CNT_W)) chkInst (
  .clk(clk), .porRstN(porRstN), .sysRstN(sysRstN), .tickEn(tickEn),
  .ctlWr(wrEn && (wrAddr == 2'd0)),
  .cfgWr(wrEn && (wrAddr == 2'd1) && wrData[31]),
  .causeClr(wrEn && (wrAddr == 2'd2) && wrData[5]),
  .timerOn(timerOn), .rstReq(rstReq), .causeFlag(causeFlag),
  .fullBusRst(fullBusRst), .cntVal(cntVal)
);

// File: tb/keyed_watchdog_test.sv
`timescale 1ns/1ps
module keyed_watchdog_test;
  localparam int CW = 8;
  localparam logic [31:0] FULL = 32'd255;

  logic clk = 1'b0;
  logic porRstN = 1'b0;
  logic sysRstN = 1'b1;
  logic tickEn = 1'b0;
  logic wrEnA = 1'b0, wrEnB = 1'b0;
  logic [1:0] wrAddr = '0, rdAddr = '0;
  logic [31:0] wrData = '0;
  logic [31:0] rdA, rdB;
  logic onA, onB, reqA, reqB, selA, selB;
  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  keyed_watchdog #(.CNT_W(CW), .CAN_STOP(1'b1)) uut (
    .clk(clk), .porRstN(porRstN), .sysRstN(sysRstN), .tickEn(tickEn),
    .wrEn(wrEnA), .wrAddr(wrAddr), .wrData(wrData), .rdAddr(rdAddr),
    .rdData(rdA), .timerOn(onA), .rstReq(reqA), .fullBusRst(selA));

  keyed_watchdog #(.CNT_W(CW), .CAN_STOP(1'b0)) uutNoStop (
    .clk(clk), .porRstN(porRstN), .sysRstN(sysRstN), .tickEn(tickEn),
    .wrEn(wrEnB), .wrAddr(wrAddr), .wrData(wrData), .rdAddr(rdAddr),
    .rdData(rdB), .timerOn(onB), .rstReq(reqB), .fullBusRst(selB));

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(bit toB, logic [1:0] a, logic [31:0] d);
    @(negedge clk);
    wrAddr = a; wrData = d;
    if (toB) wrEnB = 1'b1; else wrEnA = 1'b1;
    @(negedge clk);
    wrEnA = 1'b0; wrEnB = 1'b0;
  endtask

  task automatic rd(bit fromB, logic [1:0] a, output logic [31:0] v);
    rdAddr = a;
    #0.1;
    v = fromB ? rdB : rdA;
  endtask

  task automatic ticks(int n);
    tickEn = 1'b1;
    repeat (n) @(negedge clk);
    tickEn = 1'b0;
  endtask

  task automatic start(bit toB);
    wr(toB, 2'd0, 32'h1E1E_1E1E);
    wr(toB, 2'd0, 32'hE1E1_E1E1);
  endtask

  task automatic t_reset();
    logic [31:0] v;
    rd(0, 2'd0, v); check("R1 counter", v, FULL);
    rd(0, 2'd1, v); check("R1 cfg", v, 0);
    rd(0, 2'd2, v); check("R1 cause", v, 0);
    check("R1 on/req", {onA, reqA, selA}, 0);
  endtask

  task automatic t_start();
    logic [31:0] v;
    wr(0, 2'd0, 32'hE1E1_E1E1);
    check("R5 lone confirm", onA, 0);
    start(0);
    rd(0, 2'd0, v);
    check("R2 on", onA, 1); check("R2 counter", v, FULL);
    ticks(3);
    rd(0, 2'd0, v); check("R3 three ticks", v, FULL - 3);
    repeat (5) @(negedge clk);
    rd(0, 2'd0, v); check("R3 no tick hold", v, FULL - 3);
    for (int i = 0; i < 5; i++) begin
      tickEn = 1'b1; @(negedge clk); tickEn = 1'b0; @(negedge clk);
    end
    rd(0, 2'd0, v); check("R3 sparse ticks", v, FULL - 8);
  endtask

  task automatic t_keepalive();
    logic [31:0] v;
    start(0);
    rd(0, 2'd0, v); check("R4 reload", v, FULL);
    check("R4 still on", onA, 1);
  endtask

  task automatic t_cancel();
    logic [31:0] v;
    ticks(5);
    wr(0, 2'd0, 32'h1E1E_1E1E);
    wr(0, 2'd0, 32'h1234_5678);
    wr(0, 2'd0, 32'hE1E1_E1E1);
    rd(0, 2'd0, v); check("R5 cancelled", v, FULL - 5);
    check("R5 on", onA, 1);
    wr(0, 2'd0, 32'h1F1F_1F1F);
    wr(0, 2'd0, 32'h0000_0000);
    wr(0, 2'd0, 32'hF1F1_F1F1);
    check("R5 stop cancelled", onA, 1);
  endtask

  task automatic t_stop();
    logic [31:0] v;
    wr(0, 2'd0, 32'h1F1F_1F1F);
    wr(0, 2'd0, 32'hF1F1_F1F1);
    check("R6 stopped", onA, 0);
    ticks(4);
    rd(0, 2'd0, v); check("R6 frozen", v, FULL - 5);
    start(0);
    rd(0, 2'd0, v); check("R2 restart", v, FULL);
  endtask

  task automatic t_noStop();
    logic [31:0] v;
    start(1);
    ticks(2);
    wr(1, 2'd0, 32'h1F1F_1F1F);
    wr(1, 2'd0, 32'hF1F1_F1F1);
    check("R7 still on", onB, 1);
    ticks(1);
    rd(1, 2'd0, v); check("R7 counting", v, FULL - 3);
  endtask

  task automatic t_expire();
    logic [31:0] v;
    start(0);
    tickEn = 1'b1;
    repeat (254) @(negedge clk);
    rd(0, 2'd0, v); check("R8 at one", v, 1);
    check("R8 no req yet", reqA, 0);
    @(negedge clk);
    check("R8 req high", reqA, 1);
    check("R8 off", onA, 0);
    rd(0, 2'd2, v); check("R8 cause", v, 32'h20);
    rd(0, 2'd0, v); check("R8 zero", v, 0);
    @(negedge clk);
    check("R8 req one cycle", reqA, 0);
    repeat (3) @(negedge clk);
    tickEn = 1'b0;
    rd(0, 2'd0, v); check("R8 stays zero", v, 0);
  endtask

  task automatic t_sysRst();
    logic [31:0] v;
    wr(0, 2'd1, 32'h8000_0001);
    wr(0, 2'd0, 32'h1E1E_1E1E);
    @(negedge clk); sysRstN = 1'b0; @(negedge clk); sysRstN = 1'b1;
    rd(0, 2'd2, v); check("R9 cause kept", v, 32'h20);
    rd(0, 2'd0, v); check("R11 counter", v, FULL);
    check("R11 off", onA, 0);
    check("R11 cfg kept", selA, 1);
    wr(0, 2'd0, 32'hE1E1_E1E1);
    check("R11 arm cleared", onA, 0);
    wr(0, 2'd2, 32'h0000_0000);
    rd(0, 2'd2, v); check("R9 no clear", v, 32'h20);
    wr(0, 2'd2, 32'h0000_0020);
    rd(0, 2'd2, v); check("R9 w1c", v, 0);
  endtask

  task automatic t_cfg();
    logic [31:0] v;
    wr(0, 2'd1, 32'h8000_0000);
    check("R10 cleared", selA, 0);
    wr(0, 2'd1, 32'h0000_0001);
    rd(0, 2'd1, v); check("R10 unqualified", v, 0);
    wr(0, 2'd1, 32'h8000_0001);
    rd(0, 2'd1, v); check("R10 qualified", v, 1);
    check("R10 pin", selA, 1);
    wr(0, 2'd1, 32'h0000_0000);
    check("R10 hold", selA, 1);
  endtask

  task automatic t_por();
    logic [31:0] v;
    t_expire();
    @(negedge clk); porRstN = 1'b0; @(negedge clk); porRstN = 1'b1;
    rd(0, 2'd2, v); check("R9 por clears", v, 0);
    check("R1 cfg after por", selA, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    porRstN = 1'b1;
    @(negedge clk);
    t_reset();
    t_start();
    t_keepalive();
    t_cancel();
    t_stop();
    t_noStop();
    t_expire();
    t_sysRst();
    t_cfg();
    t_por();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule